// File: doc/BRIEF.md
# Buck converter PWM switch controller

This block is the digital timing core of a synchronous step-down converter. A free-running oscillator counter produces one pulse per switching period. Each pulse holds the low-side switch on for a fixed minimum time. When the pulse ends, a set/reset PWM latch opens the high-side phase. The analog side is reduced to two digital inputs. One says the ramp has risen above the error voltage. The other is a raw over-current flag from the high-side sense path. Either input can end the high-side phase before the next pulse.

The period is picked from two preset values by a static select input. The period and pulse counts are derived from the clock rate, so the high-side switch can never conduct for more than 90% of a period. The high-side enable is also gated by feedback that reports the low-side gate is discharged. This keeps the two switches from overlapping, whatever the external dead time. A halt input and the synchronous reset drop both enables on the next edge. The next run then starts with a fresh oscillator pulse.

Top module: `buck_pwm_ctrl`

## Requirements
- R1: With the defaults (50 MHz clock), the switching period is 143 clocks when `freq_hi` is 0 (about 350 kHz) and 91 clocks when it is 1 (about 550 kHz). `freq_hi` is sampled only at a period boundary, so a change takes effect from the next period.
- R2: Each period opens with an oscillator pulse of 15 clocks (low rate) or 10 clocks (high rate). During the pulse, `lo_on` is 1 and `hi_on` is 0.
- R3: Once the high-side switch has been on for at least the minimum on-time, `cmp_trip` sampled high ends the high-side phase. `hi_on` falls and `lo_on` rises on the next edge, and `lo_on` stays 1 until the period ends.
- R4: If `cmp_trip` stays low, the high-side phase lasts until the next oscillator pulse. The high-side on-time never exceeds 90% of the period.
- R5: If `cmp_trip` is high when the pulse ends, the high-side phase is skipped. `hi_on` stays 0 and `lo_on` stays 1 for the whole period.
- R6: `oc_raw` is ignored for the first 5 clocks (100 ns) that `hi_on` is 1.
- R7: If `oc_raw` is high for 5 consecutive clocks after blanking, `hi_on` turns off on the next edge, within 200 ns of the trip. A shorter burst has no effect. This is decided anew in every period.
- R8: `oc_raw` has no effect while `hi_on` is 0. This covers the pulse, the dead time and the low-side phase after a comparator reset.
- R9: `hi_on` rises only on an edge where `lo_gate_off` is 1, and `hi_on` and `lo_on` are never 1 together. With a feedback delay of D clocks after `lo_on` falls, `hi_on` rises D+1 clocks after `lo_on` falls.
- R10: Once on, `hi_on` stays on for at least 10 clocks (200 ns), even if `cmp_trip` is asserted earlier.
- R11: On an edge that samples `rst` or `halt` high, both enables go to 0. Run restarts one clock after release, with `lo_on` high at the start of a new oscillator pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| halt | input | 1 | Shutdown request; both switches off while high |
| freq_hi | input | 1 | Frequency select: 0 = low preset, 1 = high preset |
| cmp_trip | input | 1 | PWM comparator: ramp is above the error voltage |
| oc_raw | input | 1 | Unfiltered high-side over-current flag |
| lo_gate_off | input | 1 | Feedback: low-side gate is discharged |
| hi_on | output | 1 | High-side switch enable |
| lo_on | output | 1 | Low-side switch enable |

## Verification
The main function is exercised with several comparator patterns, and each isolates a different path. A comparator that never trips shows the maximum duty and the period length. One held high separates the skipped high-side phase from a minimum pulse. One rising late in the period checks the normal latch reset. One rising right after turn-on shows that the minimum on-time holds. Over-current is applied in four ways: a burst inside the blanking window, a burst one clock shorter than the filter, a sustained trip in two separate periods, and a flag held only while the low side conducts. Together these separate blanking from filtering, and the high-side path from the low-side path. The feedback delay is varied to show the high-side start follows the gate feedback rather than a fixed count.

// File: rtl/buck_pwm_ctrl.sv
module buck_pwm_ctrl #(
  parameter int CLK_KHZ   = 50000,
  parameter int LO_KHZ    = 350,
  parameter int HI_KHZ    = 550,
  parameter int DUTY_PCT  = 90,
  parameter int BLANK_NS  = 100,
  parameter int HOLD_NS   = 100,
  parameter int MINON_NS  = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic halt,
  input  logic freq_hi,
  input  logic cmp_trip,
  input  logic oc_raw,
  input  logic lo_gate_off,
  output logic hi_on,
  output logic lo_on
);

  localparam int CYC_NS  = 1000000 / CLK_KHZ;
  localparam int P_LO    = (CLK_KHZ + LO_KHZ / 2) / LO_KHZ;
  localparam int P_HI    = (CLK_KHZ + HI_KHZ / 2) / HI_KHZ;
  localparam int W_LO    = (P_LO * (100 - DUTY_PCT) + 99) / 100;
  localparam int W_HI    = (P_HI * (100 - DUTY_PCT) + 99) / 100;
  localparam int BLANK_C = (BLANK_NS + CYC_NS - 1) / CYC_NS;
  localparam int HOLD_C  = (HOLD_NS + CYC_NS - 1) / CYC_NS;
  localparam int MINON_C = (MINON_NS + CYC_NS - 1) / CYC_NS;
  localparam int CW      = $clog2(P_LO > P_HI ? P_LO : P_HI);
  localparam int AW      = $clog2(MINON_C + 1);
  localparam int HW      = $clog2(HOLD_C + 1);

  logic          run_q, sel_q, ph_q, hs_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] age_q;
  logic [HW-1:0] hold_q;

  logic [CW-1:0] per_m1, wid_m1;
  logic          wrap, pulse_end, oc_q, oc_cut, cmp_cut;
  logic          ph_d, hs_d;
  logic [AW-1:0] age_d;
  logic [HW-1:0] hold_d;

  assign per_m1    = sel_q ? CW'(P_HI - 1) : CW'(P_LO - 1);
  assign wid_m1    = sel_q ? CW'(W_HI - 1) : CW'(W_LO - 1);
  assign wrap      = (cnt_q == per_m1);
  assign pulse_end = (cnt_q == wid_m1);

  assign oc_q    = oc_raw & hs_q & (age_q > AW'(BLANK_C));
  assign oc_cut  = oc_q & (hold_q >= HW'(HOLD_C - 1));
  assign cmp_cut = cmp_trip & (~hs_q | (age_q >= AW'(MINON_C)));

  always_comb begin
    ph_d = ph_q;
    if (wrap)
      ph_d = 1'b0;
    else if (pulse_end)
      ph_d = ~cmp_trip;
    else if (ph_q && (cmp_cut || oc_cut))
      ph_d = 1'b0;
  end

  assign hs_d   = ph_d & lo_gate_off;
  assign age_d  = !hs_d ? '0 : (age_q == AW'(MINON_C) ? age_q : age_q + AW'(1));
  assign hold_d = !oc_q ? '0 : (hold_q == HW'(HOLD_C) ? hold_q : hold_q + HW'(1));

  always_ff @(posedge clk) begin
    if (rst || halt) begin
      run_q  <= 1'b0;
      sel_q  <= freq_hi;
      cnt_q  <= '0;
      ph_q   <= 1'b0;
      hs_q   <= 1'b0;
      age_q  <= '0;
      hold_q <= '0;
    end else if (!run_q) begin
      run_q <= 1'b1;
      sel_q <= freq_hi;
    end else begin
      cnt_q  <= wrap ? '0 : cnt_q + CW'(1);
      if (wrap) sel_q <= freq_hi;
      ph_q   <= ph_d;
      hs_q   <= hs_d;
      age_q  <= age_d;
      hold_q <= hold_d;
    end
  end

  assign hi_on = hs_q;
  assign lo_on = run_q & ~ph_q;

endmodule

// File: rtl/buck_pwm_ctrl_chk.sv
module buck_pwm_ctrl_chk #(
  parameter int MINON_C = 10,
  parameter int HS_MAX  = 128
) (
  input logic clk,
  input logic rst,
  input logic halt,
  input logic lo_gate_off,
  input logic hi_on,
  input logic lo_on
);

  logic [7:0] run_c;

  always_ff @(posedge clk) begin
    if (rst) run_c <= '0;
    else if (hi_on) run_c <= (run_c == 8'hff) ? run_c : run_c + 8'd1;
    else run_c <= '0;
  end

  p_break_before_make_r9: assert property (@(posedge clk) disable iff (rst)
    !(hi_on && lo_on));

  p_fb_gate_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(hi_on) |-> $past(lo_gate_off));

  p_halt_off_r11: assert property (@(posedge clk) disable iff (rst)
    halt |=> (!hi_on && !lo_on));

  p_min_on_r10: assert property (@(posedge clk) disable iff (rst || halt)
    ($fell(hi_on) && !$past(halt) && !$past(rst)) |-> (run_c >= 8'(MINON_C)));

  p_duty_cap_r4: assert property (@(posedge clk) disable iff (rst)
    hi_on |-> (run_c < 8'(HS_MAX)));

endmodule

bind buck_pwm_ctrl buck_pwm_ctrl_chk chk_i (
  .clk(clk), .rst(rst), .halt(halt), .lo_gate_off(lo_gate_off),
  .hi_on(hi_on), .lo_on(lo_on)
);

// File: tb/buck_pwm_ctrl_tb_top.sv
module buck_pwm_ctrl_tb_top;

  localparam int PLO = 143, PHI = 91, WLO = 15, WHI = 10;
  localparam int BLANK = 5, HOLD = 5, MINON = 10;

  logic clk = 1'b0;
  logic rst = 1'b1, halt = 1'b0, freq_hi = 1'b0;
  logic cmp_trip = 1'b0, oc_raw = 1'b0;
  logic lo_gate_off, hi_on, lo_on;
  logic [7:0] fb_sr = '0;
  int fb_dly = 2;

  int nchk = 0, nerr = 0, overlap = 0;
  bit done = 0;

  int c_lo = -1, c_hi = -1, o_lo = -1, o_hi = -1, o2_lo = -1, o2_hi = -1;

  // reference model state
  bit m_run = 0, m_ph = 0, m_hi = 0, m_lo = 0, m_cut;
  int m_pos = 0, m_len = PLO, m_wid = WLO, m_age = 0, m_ocn = 0;

  buck_pwm_ctrl dut_i (
    .clk(clk), .rst(rst), .halt(halt), .freq_hi(freq_hi), .cmp_trip(cmp_trip),
    .oc_raw(oc_raw), .lo_gate_off(lo_gate_off), .hi_on(hi_on), .lo_on(lo_on)
  );

  always #10 clk = ~clk;

  always @(posedge clk) fb_sr <= {fb_sr[6:0], ~lo_on};
  assign lo_gate_off = fb_sr[fb_dly-1];

  function automatic bit in_rng(input int p, input int lo, input int hi);
    return (lo >= 0) && (p >= lo) && (p <= hi);
  endfunction

  always @(posedge clk) begin
    if (rst || halt) begin
      m_run = 0; m_pos = 0; m_ph = 0; m_hi = 0; m_age = 0; m_ocn = 0;
      m_len = freq_hi ? PHI : PLO; m_wid = freq_hi ? WHI : WLO;
    end else if (!m_run) begin
      m_run = 1;
      m_len = freq_hi ? PHI : PLO; m_wid = freq_hi ? WHI : WLO;
    end else begin
      m_cut = 0;
      if (m_hi && oc_raw && m_age > BLANK) m_ocn = m_ocn + 1; else m_ocn = 0;
      if (m_ocn >= HOLD) m_cut = 1;
      if (cmp_trip && (!m_hi || m_age >= MINON)) m_cut = 1;
      if (m_pos == m_len - 1) begin
        m_pos = 0; m_ph = 0;
        m_len = freq_hi ? PHI : PLO; m_wid = freq_hi ? WHI : WLO;
      end else begin
        m_pos = m_pos + 1;
        if (m_pos == m_wid) m_ph = !cmp_trip;
        else if (m_ph && m_cut) m_ph = 0;
      end
      m_hi = m_ph && lo_gate_off;
      m_age = m_hi ? m_age + 1 : 0;
    end
    m_lo = m_run && !m_ph;
  end

  always @(negedge clk) begin
    cmp_trip = in_rng(m_pos, c_lo, c_hi);
    oc_raw = in_rng(m_pos, o_lo, o_hi) || in_rng(m_pos, o2_lo, o2_hi);
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      nchk++;
      if (hi_on && lo_on) overlap++;
      if (hi_on !== m_hi || lo_on !== m_lo) begin
        nerr++;
        $display("FAIL %s model compare at pos %0d: hi=%b lo=%b expected hi=%b lo=%b",
                 m_hi ? "R3" : (m_pos < m_wid ? "R2" : "R9"), m_pos, hi_on, lo_on, m_hi, m_lo);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic measure(input int flip_at, output int per, output int pw,
                         output int hs_c, output int ls_c, output int hs_st);
    @(negedge clk);
    while (!(m_run && m_pos == 0)) @(negedge clk);
    per = 0; pw = -1; hs_c = 0; ls_c = 0; hs_st = -1;
    do begin
      if (per == flip_at) freq_hi = ~freq_hi;
      if (hi_on) begin hs_c++; if (hs_st < 0) hs_st = per; end
      if (lo_on) ls_c++; else if (pw < 0) pw = per;
      per++;
      @(negedge clk);
    end while (m_pos != 0);
  endtask

  task automatic ranges_off();
    c_lo = -1; c_hi = -1; o_lo = -1; o_hi = -1; o2_lo = -1; o2_hi = -1;
  endtask

  task automatic summary();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    nchk++; nerr++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    int per, pw, hs, ls, st;
    repeat (3) @(negedge clk);
    chk("R11 reset hi_on", int'(hi_on), 0);
    chk("R11 reset lo_on", int'(lo_on), 0);
    rst = 0;

    measure(-1, per, pw, hs, ls, st);
    chk("R1 low period", per, PLO);
    chk("R2 low pulse width", pw, WLO);
    chk("R4 full high-side time", hs, PLO - WLO - 1 - 2);
    chk("R4 duty at most 90pct", int'(hs * 100 <= 90 * per), 1);
    chk("R9 high-side start after feedback", st, WLO + 2 + 1);

    freq_hi = 1;
    measure(-1, per, pw, hs, ls, st);
    chk("R1 high period", per, PHI);
    chk("R2 high pulse width", pw, WHI);
    chk("R4 high-rate high-side time", hs, PHI - WHI - 3);
    measure(30, per, pw, hs, ls, st);
    chk("R1 select change keeps current period", per, PHI);
    measure(-1, per, pw, hs, ls, st);
    chk("R1 select change applies next period", per, PLO);

    c_lo = 0; c_hi = 100000;
    measure(-1, per, pw, hs, ls, st);
    chk("R5 comparator held: no high-side", hs, 0);
    chk("R5 comparator held: low-side whole period", ls, PLO);

    c_lo = 60;
    measure(-1, per, pw, hs, ls, st);
    chk("R3 comparator reset high-side time", hs, 60 - 18 + 1);
    chk("R3 low-side rest of period", ls, WLO + (PLO - 61));

    c_lo = 20;
    measure(-1, per, pw, hs, ls, st);
    chk("R10 minimum on-time", hs, MINON);

    ranges_off(); o_lo = 18; o_hi = 22;
    measure(-1, per, pw, hs, ls, st);
    chk("R6 flag inside blanking ignored", hs, PLO - WLO - 3);

    o_lo = 40; o_hi = 43;
    measure(-1, per, pw, hs, ls, st);
    chk("R7 short flag ignored", hs, PLO - WLO - 3);

    o_lo = 50; o_hi = 100000;
    measure(-1, per, pw, hs, ls, st);
    chk("R7 sustained trip period A", hs, 54 - 18 + 1);
    measure(-1, per, pw, hs, ls, st);
    chk("R7 sustained trip period B", hs, 54 - 18 + 1);

    o_lo = 0;
    measure(-1, per, pw, hs, ls, st);
    chk("R7 off within 200 ns of turn-on", hs, MINON);

    ranges_off(); c_lo = 60; c_hi = 100000;
    o_lo = 0; o_hi = 17; o2_lo = 61; o2_hi = 100000;
    measure(-1, per, pw, hs, ls, st);
    chk("R8 flag during low-side ignored", hs, 60 - 18 + 1);

    ranges_off(); fb_dly = 5;
    measure(-1, per, pw, hs, ls, st);
    measure(-1, per, pw, hs, ls, st);
    chk("R9 gap tracks feedback delay", st - pw, 6);
    chk("R9 high-side time with long dead time", hs, PLO - WLO - 6);

    fb_dly = 2;
    measure(-1, per, pw, hs, ls, st);
    while (m_pos != 40) @(negedge clk);
    halt = 1;
    @(negedge clk);
    chk("R11 halt drops hi_on", int'(hi_on), 0);
    chk("R11 halt drops lo_on", int'(lo_on), 0);
    repeat (3) @(negedge clk);
    chk("R11 halt holds both off", int'(hi_on | lo_on), 0);
    halt = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R11 restart with low-side pulse", int'(lo_on && !hi_on), 1);
    measure(-1, per, pw, hs, ls, st);
    chk("R11 period after restart", per, PLO);
    chk("R2 pulse after restart", pw, WLO);

    chk("R9 no overlap seen", overlap, 0);
    summary();
  end

endmodule